// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block arbitrates six level-sensitive interrupt request lines from peripherals and presents a single interrupt call to a processor core. A per-source enable vector and a global enable decide which requests may compete. A per-source priority vector places each source in one of two preemption levels. The block picks a winner and raises a call with the winner's vector index. It holds that call until the core accepts it with a take strobe, then pulses an acknowledge to the winning source.

The controller keeps one in-service flag per level. A handler running at the low level can be preempted only by a high-level request. While a high-level handler runs, nothing is taken. A return strobe from the core closes the innermost open level. Saving context and steering the program counter are done by the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `call_req` is 0, `vec_idx` is 0, `ack` is all zeros, and both in-service flags are 0.
- R2: A request line `irq_req[i]` can lead to a call only while `src_en[i]` and `glb_en` are both 1.
- R3: Among the allowed requests, any high-priority source (`prio_hi[i]`=1) wins over every low-priority source. Within one level, the lowest source index wins.
- R4: Once `call_req` is 1, it and `vec_idx` hold their values until a take strobe. Requests that arrive, change or drop in the meantime do not alter them.
- R5: A `take` pulse while `call_req` is 1 clears `call_req` on the next clock edge. At that same edge, `ack` becomes one-hot for exactly one cycle. A `take` pulse while `call_req` is 0 has no effect.
- R6: An accepted take sets the in-service flag of the winner's level: `svc_hi` for a high-priority source, `svc_lo` for a low-priority source.
- R7: While `svc_hi` is 1, no call is raised. While only `svc_lo` is 1, only high-priority requests can raise a call.
- R8: A `reti` pulse clears `svc_hi` if it is set, and otherwise clears `svc_lo`. With both flags clear, `reti` changes nothing.
- R9: When `take` and `reti` fall in the same cycle, the return acts on the flags as they stood before that cycle, and the taken level's flag is then set.
- R10: `vec_idx` carries the winning source number 0 to 5 in binary, and `ack` bit i belongs to source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 6 | Level-sensitive request, one bit per source |
| src_en | input | 6 | Per-source enable |
| glb_en | input | 1 | Global enable |
| prio_hi | input | 6 | Per-source level: 1 means high, 0 means low |
| take | input | 1 | One-cycle strobe from the core accepting the call |
| reti | input | 1 | One-cycle return-from-interrupt strobe |
| call_req | output | 1 | Interrupt call request to the core |
| vec_idx | output | 3 | Vector table index of the winning source |
| ack | output | 6 | One-cycle acknowledge to the winning source |
| svc_lo | output | 1 | Low level in service |
| svc_hi | output | 1 | High level in service |

## Verification
A take of a high-priority call and a return can land in the same cycle. The bench provokes this by first servicing a low-priority source, then raising a high-priority request and pulsing `take` and `reti` together. The case is judged correct when the low flag is cleared, the high flag is set and the high source gets its acknowledge. A scoreboard queue pairs each accepted take with the acknowledge it expects. Direct checks cover suppression of requests under the in-service rules and stability of a pending call.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_trk.sv
module irq_level_trk
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  lvl_e set_lvl,
  input  logic pop,
  output logic svc_lo,
  output logic svc_hi
);
  logic lo_n, hi_n;

  always_comb begin
    lo_n = svc_lo;
    hi_n = svc_hi;
    if (pop) begin
      if (svc_hi) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (set_en) begin
      if (set_lvl == LVL_HI) hi_n = 1'b1;
      else                   lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_lo <= 1'b0;
      svc_hi <= 1'b0;
    end else begin
      svc_lo <= lo_n;
      svc_hi <= hi_n;
    end
  end

  // R8: return closes the high level first and leaves the low one alone
  p_pop_hi_first_r8: assert property (@(posedge clk) disable iff (rst)
    pop && svc_hi && !set_en |=> !svc_hi && (svc_lo == $past(svc_lo)));
  // R8: return with only low open clears low
  p_pop_lo_r8: assert property (@(posedge clk) disable iff (rst)
    pop && !svc_hi && !set_en |=> !svc_lo && !svc_hi);
  // R6: flags only rise through an accepted take
  p_rise_by_take_r6: assert property (@(posedge clk) disable iff (rst)
    !set_en |=> !$rose(svc_lo) && !$rose(svc_hi));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 6,
  localparam int IW   = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic             take,
  input  logic             reti,
  output logic             call_req,
  output logic [IW-1:0]    vec_idx,
  output logic [N_SRC-1:0] ack,
  output logic             svc_lo,
  output logic             svc_hi
);
  logic [N_SRC-1:0] elig, cand_hi, cand_lo;
  logic             f_hi, f_lo;
  logic [IW-1:0]    i_hi, i_lo;
  logic             win_ok;
  logic [IW-1:0]    win_idx;
  lvl_e             win_lvl, call_lvl;
  logic             accept;

  assign elig    = irq_req & src_en & {N_SRC{glb_en}};
  assign cand_hi = elig & prio_hi;
  assign cand_lo = elig & ~prio_hi;

  irq_pick #(.N(N_SRC), .IW(IW)) u_pick_hi (.cand(cand_hi), .found(f_hi), .idx(i_hi));
  irq_pick #(.N(N_SRC), .IW(IW)) u_pick_lo (.cand(cand_lo), .found(f_lo), .idx(i_lo));

  // level gating by in-service state
  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_lvl = LVL_LO;
    if (!svc_hi) begin
      if (f_hi) begin
        win_ok  = 1'b1;
        win_idx = i_hi;
        win_lvl = LVL_HI;
      end else if (f_lo && !svc_lo) begin
        win_ok  = 1'b1;
        win_idx = i_lo;
      end
    end
  end

  assign accept = call_req && take;

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req <= 1'b0;
      vec_idx  <= '0;
      call_lvl <= LVL_LO;
      ack      <= '0;
    end else begin
      ack <= '0;
      if (accept) begin
        call_req     <= 1'b0;
        ack[vec_idx] <= 1'b1;
      end else if (!call_req && win_ok) begin
        call_req <= 1'b1;
        vec_idx  <= win_idx;
        call_lvl <= win_lvl;
      end
    end
  end

  irq_level_trk u_trk (
    .clk(clk), .rst(rst), .set_en(accept), .set_lvl(call_lvl),
    .pop(reti), .svc_lo(svc_lo), .svc_hi(svc_hi)
  );

  // R4: pending call holds until take
  p_call_hold_r4: assert property (@(posedge clk) disable iff (rst)
    call_req && !take |=> call_req && $stable(vec_idx));
  // R5: accepted take yields an acknowledge next cycle and drops the call
  p_ack_follows_take_r5: assert property (@(posedge clk) disable iff (rst)
    call_req && take |=> (ack != '0) && !call_req);
  // R5: acknowledge is one-hot and lasts one cycle
  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));
  p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
    (ack != '0) |=> (ack == '0));
  // R7: nothing is raised while the high level is in service
  p_block_when_hi_r7: assert property (@(posedge clk) disable iff (rst)
    svc_hi && !call_req |=> !call_req);
  // R2: no call without global enable
  p_need_glb_r2: assert property (@(posedge clk) disable iff (rst)
    !glb_en && !call_req |=> !call_req);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int N = 6;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] irq_req = '0, src_en = '0, prio_hi = '0;
  logic glb_en = 1'b0, take = 1'b0, reti = 1'b0;
  logic call_req, svc_lo, svc_hi;
  logic [2:0] vec_idx;
  logic [N-1:0] ack;

  int total = 0, bad = 0;
  logic [N-1:0] exp_q[$];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .src_en(src_en), .glb_en(glb_en),
    .prio_hi(prio_hi), .take(take), .reti(reti), .call_req(call_req),
    .vec_idx(vec_idx), .ack(ack), .svc_lo(svc_lo), .svc_hi(svc_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // monitor: compare each acknowledge against the scoreboard
  always @(negedge clk) begin
    if (!rst && ack != '0) begin
      if (exp_q.size() == 0) chk("R5 unexpected ack", 32'(ack), 32'h0);
      else chk("R10 ack source", 32'(ack), 32'(exp_q.pop_front()));
    end
  end

  // driver: accept pending call for source idx
  task automatic serve(input int idx, input string req);
    chk({req, " call"}, 32'(call_req), 32'h1);
    chk({req, " vec"}, 32'(vec_idx), 32'(idx));
    exp_q.push_back(N'(1) << idx);
    take = 1'b1;
    tick();
    take = 1'b0;
    chk("R5 call dropped", 32'(call_req), 32'h0);
    irq_req[idx] = 1'b0;
    tick();
    chk("R5 ack one cycle", 32'(ack), 32'h0);
  endtask

  task automatic ret();
    reti = 1'b1;
    tick();
    reti = 1'b0;
  endtask

  task automatic flags(input logic lo, input logic hi, input string req);
    chk({req, " svc_lo"}, 32'(svc_lo), 32'(lo));
    chk({req, " svc_hi"}, 32'(svc_hi), 32'(hi));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1
    chk("R1 call", 32'(call_req), 32'h0);
    chk("R1 vec", 32'(vec_idx), 32'h0);
    chk("R1 ack", 32'(ack), 32'h0);
    flags(1'b0, 1'b0, "R1");

    // R2: gating by global and per-source enable
    src_en = '1; irq_req[2] = 1'b1;
    tick(); tick(); tick();
    chk("R2 glb off", 32'(call_req), 32'h0);
    glb_en = 1'b1; src_en[2] = 1'b0;
    tick(); tick(); tick();
    chk("R2 src off", 32'(call_req), 32'h0);
    src_en[2] = 1'b1;
    tick(); tick();
    serve(2, "R2");
    flags(1'b1, 1'b0, "R6 low taken");

    // R7: under low service only high requests pass
    irq_req[0] = 1'b1;
    tick(); tick(); tick();
    chk("R7 low blocked", 32'(call_req), 32'h0);
    prio_hi[4] = 1'b1; prio_hi[5] = 1'b1; irq_req[4] = 1'b1;
    tick(); tick();
    serve(4, "R7 nest");
    flags(1'b1, 1'b1, "R6 high taken");
    irq_req[5] = 1'b1;
    tick(); tick(); tick();
    chk("R7 high blocked", 32'(call_req), 32'h0);
    ret();
    flags(1'b1, 1'b0, "R8 pop high");
    tick();
    serve(5, "R8 after pop");
    irq_req[0] = 1'b0;
    ret();
    flags(1'b1, 1'b0, "R8 pop high again");
    ret();
    flags(1'b0, 1'b0, "R8 pop low");
    ret();
    flags(1'b0, 1'b0, "R8 empty pop");
    chk("R8 empty no call", 32'(call_req), 32'h0);

    // R3: level then index ordering
    prio_hi = 6'b111000;
    irq_req = 6'b101010;
    tick(); tick();
    serve(3, "R3 hi lowest");
    ret();
    tick();
    serve(5, "R3 hi next");
    ret();
    tick();
    serve(1, "R3 low last");
    ret();
    flags(1'b0, 1'b0, "R3 end");

    // R4: pending call is not displaced
    irq_req[1] = 1'b1;
    tick(); tick();
    chk("R4 raised", 32'(vec_idx), 32'h1);
    irq_req[4] = 1'b1;
    tick(); tick(); tick();
    chk("R4 held", 32'(vec_idx), 32'h1);
    serve(1, "R4");
    tick();
    serve(4, "R4 later");
    ret(); ret();
    flags(1'b0, 1'b0, "R4 end");

    // R5: take with nothing pending
    take = 1'b1;
    tick();
    take = 1'b0;
    chk("R5 stray take ack", 32'(ack), 32'h0);
    flags(1'b0, 1'b0, "R5 stray take");

    // R9: take and return in the same cycle
    irq_req[0] = 1'b1;
    tick(); tick();
    serve(0, "R9 setup");
    irq_req[3] = 1'b1;
    tick(); tick();
    chk("R9 call", 32'(vec_idx), 32'h3);
    exp_q.push_back(6'b001000);
    take = 1'b1; reti = 1'b1;
    tick();
    take = 1'b0; reti = 1'b0; irq_req[3] = 1'b0;
    flags(1'b0, 1'b1, "R9");
    tick();
    ret();
    flags(1'b0, 1'b0, "R9 end");

    chk("R5 all acks seen", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule